// File: doc/BRIEF.md
# Load/Store-Multiple Micro-op Sequencer

This block takes one block-transfer instruction (a load-multiple or store-multiple over a 16-entry register list) and breaks it into a stream of micro-op descriptors. The decode stage offers the instruction on a valid/ready handshake. The block then sends one descriptor per cycle to the back end on a second valid/ready handshake. Memory access, the register file and exception handling are all outside the block. They only ever see descriptors.

A descriptor carries an opcode, up to two destination registers, a base register, an offset magnitude with a direction bit, and several tags: user-bank access, control, indirect, conditional, return, delayed-commit and last. Three cases change the shape of the stream. Two neighbouring loads are merged into one paired load. The base is copied to a scratch register when a load would overwrite it, and also when the list is empty. A load of the program counter (register 15) turns into a tagged indirect branch, or into a deferred register-move-return, depending on writeback.

Top module: `lms_seq`

## Requirements
- R1: `in_ready` is high only while no instruction is in flight. `out_valid` stays low when idle. A descriptor held with `out_ready` low stays unchanged. After the final descriptor is taken, the block is idle on the next cycle.
- R2: Opcodes are 0 copy-base, 1 single load, 2 paired load, 3 store, 4 add-immediate, 5 sub-immediate, 6 move-return. The stream order is: optional copy, then memory descriptors, then optional writeback, then optional move-return. Memory descriptors visit set list bits in ascending register index and skip clear bits. Their transfers total the population count of the list.
- R3: With `in_up`=1 the first transfer offset is 0 and each later register adds 4. With `in_up`=0 the first offset is 4·count−4 and each later register subtracts 4. A memory descriptor's offset is that of its first register. `out_dn` equals the inverse of `in_up` on memory descriptors.
- R4: A load whose list holds the base index, or any empty list, starts with opcode 0, rd=16, base=`in_base`. All memory descriptors then use base 16. Otherwise they use `in_base`.
- R5: A load with at least two registers left emits opcode 2, with rd and rd2 the next two selected registers. The exception is an exception return whose second register would be 15: that register gets a single load.
- R6: In user mode with list bit 15 clear, every memory descriptor has `out_user`=1. In all other cases `out_user` is 0.
- R7: A load of register 15 without writeback sets `out_ctrl` and `out_indir` on that descriptor. `out_cond` is set when `in_uncond`=0. `out_ret` is also set when user mode and bit 15 are both set (exception return).
- R8: A load of register 15 with writeback sends that value to rd 17 with no control tags. The stream then ends with opcode 6, rd=15, base=17, tagged control, indirect and return, and conditional when `in_uncond`=0.
- R9: With `in_wb`=1 and a non-empty list, a descriptor with rd=base=`in_base` and offset 4·count follows the memory descriptors. Its opcode is 4 when `in_up`=1 and 5 when `in_up`=0.
- R10: Every descriptor except the final one has `out_dcommit`=1 and `out_last`=0. The final one has `out_dcommit`=0 and `out_last`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Block idle, instruction accepted |
| in_list | input | 16 | Register list |
| in_base | input | 4 | Base register index |
| in_load | input | 1 | 1 = load, 0 = store |
| in_up | input | 1 | 1 = ascending offsets |
| in_wb | input | 1 | Base writeback |
| in_user | input | 1 | User-mode variant |
| in_uncond | input | 1 | Instruction condition is always-true |
| out_valid | output | 1 | Descriptor valid |
| out_ready | input | 1 | Descriptor taken |
| out_opc | output | 3 | Opcode |
| out_rd | output | 5 | First destination/source register |
| out_rd2 | output | 5 | Second register of a paired load |
| out_base | output | 5 | Base register |
| out_off | output | 7 | Offset magnitude |
| out_dn | output | 1 | Offset subtracted |
| out_user | output | 1 | User-bank access |
| out_ctrl | output | 1 | Control transfer |
| out_indir | output | 1 | Indirect control |
| out_cond | output | 1 | Conditional control |
| out_ret | output | 1 | Return |
| out_dcommit | output | 1 | Delayed commit |
| out_last | output | 1 | Final descriptor |

## Verification
Two things can fall in the same cycle: merging two loads into a pair, and detecting a load of register 15. The pair may be the descriptor that carries the PC, either as its control-tagged second register or as a write to the scratch register 17. In an exception return the pair is refused and split instead. The sweep provokes this with every combination of load, direction, writeback and user mode over lists that include bit 15 with an odd or even number of other bits. The bench's independent model predicts whether the final transfer is paired, split, redirected or tagged, and it compares every field of every descriptor while `out_ready` stalls at random.

// File: rtl/lms_pkg.sv
package lms_pkg;
  localparam int NREG = 16;
  localparam int IW   = $clog2(NREG);
  localparam int RW   = IW + 1;
  localparam int CW   = $clog2(NREG) + 1;
  localparam int OW   = CW + 2;
  localparam int PCR  = NREG - 1;
  localparam int TMP0 = NREG;
  localparam int TMP1 = NREG + 1;

  typedef enum logic [2:0] {
    OP_COPY = 3'd0,
    OP_LDR  = 3'd1,
    OP_LDP  = 3'd2,
    OP_STR  = 3'd3,
    OP_ADDI = 3'd4,
    OP_SUBI = 3'd5,
    OP_MOVR = 3'd6
  } opc_e;

  typedef enum logic [1:0] {
    PH_COPY = 2'd0,
    PH_MEM  = 2'd1,
    PH_WB   = 2'd2,
    PH_RET  = 2'd3
  } phase_e;

  typedef struct packed {
    opc_e          opc;
    logic [RW-1:0] rd;
    logic [RW-1:0] rd2;
    logic [RW-1:0] base;
    logic [OW-1:0] off;
    logic          dn;
    logic          user;
    logic          ctrl;
    logic          indir;
    logic          cond;
    logic          ret;
    logic          dcommit;
    logic          last;
  } uop_t;
endpackage

// File: rtl/lms_plan.sv
module lms_plan #(
  parameter int N  = 16,
  parameter int BW = $clog2(N),
  parameter int KW = $clog2(N) + 1
) (
  input  logic [N-1:0]  list,
  input  logic [BW-1:0] base,
  input  logic          load,
  input  logic          wb,
  input  logic          user,
  output logic [KW-1:0] cnt,
  output logic          copy,
  output logic          xret,
  output logic          fuser,
  output logic          pctmp
);
  always_comb begin
    cnt = '0;
    for (int i = 0; i < N; i++) cnt = cnt + KW'(list[i]);
  end

  assign copy  = (load && list[base]) || (list == '0);
  assign xret  = user && list[N-1];
  assign fuser = user && !list[N-1];
  assign pctmp = load && wb && list[N-1];
endmodule

// File: rtl/lms_pick.sv
module lms_pick #(
  parameter int N  = 16,
  parameter int BW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  output logic [BW-1:0] idx1,
  output logic          hit1,
  output logic [BW-1:0] idx2,
  output logic          hit2
);
  logic [N-1:0] rest;

  always_comb begin
    idx1 = '0;
    for (int i = N - 1; i >= 0; i--) if (mask[i]) idx1 = BW'(i);
  end

  assign hit1 = |mask;
  assign rest = mask & ~(N'(1) << idx1);

  always_comb begin
    idx2 = '0;
    for (int i = N - 1; i >= 0; i--) if (rest[i]) idx2 = BW'(i);
  end

  assign hit2 = |rest;
endmodule

// File: rtl/lms_seq.sv
module lms_seq
  import lms_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [NREG-1:0] in_list,
  input  logic [IW-1:0]   in_base,
  input  logic            in_load,
  input  logic            in_up,
  input  logic            in_wb,
  input  logic            in_user,
  input  logic            in_uncond,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [2:0]      out_opc,
  output logic [RW-1:0]   out_rd,
  output logic [RW-1:0]   out_rd2,
  output logic [RW-1:0]   out_base,
  output logic [OW-1:0]   out_off,
  output logic            out_dn,
  output logic            out_user,
  output logic            out_ctrl,
  output logic            out_indir,
  output logic            out_cond,
  output logic            out_ret,
  output logic            out_dcommit,
  output logic            out_last
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rsync_q;
  logic       rst_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ok = rsync_q[1];

  // instruction plan from the offered inputs
  logic [CW-1:0] pl_cnt;
  logic          pl_copy, pl_xret, pl_fuser, pl_pctmp;
  lms_plan #(.N(NREG), .BW(IW), .KW(CW)) plan_i (
    .list (in_list), .base (in_base), .load (in_load), .wb (in_wb),
    .user (in_user), .cnt (pl_cnt), .copy (pl_copy), .xret (pl_xret),
    .fuser(pl_fuser), .pctmp(pl_pctmp)
  );

  // state
  logic          busy_q;
  phase_e        ph_q, ph_n;
  logic [NREG-1:0] rem_q, rem_n;
  logic [OW-1:0] off_q, off_n;
  logic [IW-1:0] base_q;
  logic [CW-1:0] cnt_q;
  logic          ld_q, up_q, wb_q, unc_q, cp_q, xr_q, fu_q, pt_q;

  logic [IW-1:0] p1_idx, p2_idx;
  logic          p1_hit, p2_hit;
  lms_pick #(.N(NREG), .BW(IW)) pick_i (
    .mask(rem_q), .idx1(p1_idx), .hit1(p1_hit), .idx2(p2_idx), .hit2(p2_hit)
  );

  function automatic logic [RW-1:0] dst_map(input logic [IW-1:0] r);
    if (ld_q && pt_q && r == IW'(PCR)) return RW'(TMP1);
    return {1'b0, r};
  endfunction

  logic acc, fire, fin, pair, pc_hit, wb_en;
  uop_t d;
  logic [OW-1:0] step;

  assign acc      = in_valid && !busy_q && rst_ok;
  assign fire     = busy_q && out_ready;
  assign in_ready = !busy_q && rst_ok;
  assign wb_en    = wb_q && (cnt_q != '0);

  // next-state and descriptor
  always_comb begin
    d      = '0;
    rem_n  = rem_q;
    off_n  = off_q;
    ph_n   = ph_q;
    fin    = 1'b0;
    pair   = 1'b0;
    pc_hit = 1'b0;
    step   = OW'(4);
    unique case (ph_q)
      PH_COPY: begin
        d.opc  = OP_COPY;
        d.rd   = RW'(TMP0);
        d.base = {1'b0, base_q};
      end
      PH_MEM: begin
        pair   = ld_q && p2_hit && !(xr_q && p2_idx == IW'(PCR));
        pc_hit = ld_q && (pair ? (p2_idx == IW'(PCR)) : (p1_idx == IW'(PCR)));
        d.opc  = !ld_q ? OP_STR : (pair ? OP_LDP : OP_LDR);
        d.rd   = dst_map(p1_idx);
        d.rd2  = pair ? dst_map(p2_idx) : '0;
        d.base = cp_q ? RW'(TMP0) : {1'b0, base_q};
        d.off  = off_q;
        d.dn   = !up_q;
        d.user = fu_q;
        d.ctrl  = pc_hit && !pt_q;
        d.indir = pc_hit && !pt_q;
        d.cond  = pc_hit && !pt_q && !unc_q;
        d.ret   = pc_hit && !pt_q && xr_q;
        rem_n  = rem_q & ~(NREG'(1) << p1_idx) & ~(pair ? (NREG'(1) << p2_idx) : '0);
        step   = pair ? OW'(8) : OW'(4);
        off_n  = up_q ? (off_q + step) : (off_q - step);
      end
      PH_WB: begin
        d.opc  = up_q ? OP_ADDI : OP_SUBI;
        d.rd   = {1'b0, base_q};
        d.base = {1'b0, base_q};
        d.off  = {cnt_q, 2'b00};
      end
      default: begin
        d.opc   = OP_MOVR;
        d.rd    = RW'(PCR);
        d.base  = RW'(TMP1);
        d.ctrl  = 1'b1;
        d.indir = 1'b1;
        d.ret   = 1'b1;
        d.cond  = !unc_q;
      end
    endcase
    if (ph_q == PH_MEM && rem_n != '0)                   ph_n = PH_MEM;
    else if (ph_q == PH_COPY && cnt_q != '0)             ph_n = PH_MEM;
    else if ((ph_q == PH_COPY || ph_q == PH_MEM) && wb_en) ph_n = PH_WB;
    else if (ph_q != PH_RET && pt_q)                     ph_n = PH_RET;
    else                                                 fin  = 1'b1;
    d.last    = fin;
    d.dcommit = !fin;
    if (!busy_q) d = '0;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= PH_COPY;
      rem_q  <= '0;
      off_q  <= '0;
      base_q <= '0;
      cnt_q  <= '0;
      {ld_q, up_q, wb_q, unc_q, cp_q, xr_q, fu_q, pt_q} <= '0;
    end else if (!rst_ok) begin
      busy_q <= 1'b0;
    end else if (acc) begin
      busy_q <= 1'b1;
      ph_q   <= pl_copy ? PH_COPY : PH_MEM;
      rem_q  <= in_list;
      off_q  <= in_up ? '0 : ({pl_cnt, 2'b00} - OW'(4));
      base_q <= in_base;
      cnt_q  <= pl_cnt;
      {ld_q, up_q, wb_q, unc_q} <= {in_load, in_up, in_wb, in_uncond};
      {cp_q, xr_q, fu_q, pt_q}  <= {pl_copy, pl_xret, pl_fuser, pl_pctmp};
    end else if (fire) begin
      if (fin) busy_q <= 1'b0;
      ph_q  <= ph_n;
      rem_q <= rem_n;
      off_q <= off_n;
    end
  end

  assign out_valid   = busy_q;
  assign out_opc     = d.opc;
  assign out_rd      = d.rd;
  assign out_rd2     = d.rd2;
  assign out_base    = d.base;
  assign out_off     = d.off;
  assign out_dn      = d.dn;
  assign out_user    = d.user;
  assign out_ctrl    = d.ctrl;
  assign out_indir   = d.indir;
  assign out_cond    = d.cond;
  assign out_ret     = d.ret;
  assign out_dcommit = d.dcommit;
  assign out_last    = d.last;
endmodule

// File: rtl/lms_seq_chk.sv
module lms_seq_chk
  import lms_pkg::*;
(
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [2:0]    out_opc,
  input logic [RW-1:0] out_rd,
  input logic [RW-1:0] out_rd2,
  input logic [OW-1:0] out_off,
  input logic          out_ctrl,
  input logic          out_ret,
  input logic          out_last
);
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_opc) && $stable(out_rd)
                                && $stable(out_rd2) && $stable(out_off));

  a_r1_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last |=> !out_valid && in_ready);

  a_r10_continue: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !out_last |=> out_valid);

  a_r5_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_opc == 3'd2 |-> out_rd2 > out_rd);

  a_r8_ret_is_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ret |-> out_ctrl);

  a_r9_wb_amount: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_opc == 3'd4 || out_opc == 3'd5) |-> out_off[1:0] == 2'b00 && out_off != '0);
endmodule

bind lms_seq lms_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_opc(out_opc), .out_rd(out_rd), .out_rd2(out_rd2),
  .out_off(out_off), .out_ctrl(out_ctrl), .out_ret(out_ret), .out_last(out_last)
);

// File: tb/lms_seq_tb.sv
module lms_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #2.5 clk = ~clk;

  logic in_valid, in_ready, in_load, in_up, in_wb, in_user, in_uncond;
  logic [15:0] in_list;
  logic [3:0]  in_base;
  logic out_valid, out_ready;
  logic [2:0] out_opc;
  logic [4:0] out_rd, out_rd2, out_base;
  logic [6:0] out_off;
  logic out_dn, out_user, out_ctrl, out_indir, out_cond, out_ret, out_dcommit, out_last;

  lms_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_list(in_list), .in_base(in_base), .in_load(in_load), .in_up(in_up),
    .in_wb(in_wb), .in_user(in_user), .in_uncond(in_uncond),
    .out_valid(out_valid), .out_ready(out_ready), .out_opc(out_opc),
    .out_rd(out_rd), .out_rd2(out_rd2), .out_base(out_base), .out_off(out_off),
    .out_dn(out_dn), .out_user(out_user), .out_ctrl(out_ctrl), .out_indir(out_indir),
    .out_cond(out_cond), .out_ret(out_ret), .out_dcommit(out_dcommit), .out_last(out_last)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [15:0] lfsr = 16'hACE1;

  int e_opc[24], e_rd[24], e_rd2[24], e_base[24], e_off[24];
  bit e_dn[24], e_user[24], e_ctrl[24], e_cond[24], e_ret[24];
  int ne;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  task automatic push(input int op, input int rd, input int rd2, input int b, input int off,
                      input bit dn, input bit us, input bit ct, input bit cd, input bit rt);
    e_opc[ne] = op; e_rd[ne] = rd; e_rd2[ne] = rd2; e_base[ne] = b; e_off[ne] = off;
    e_dn[ne] = dn; e_user[ne] = us; e_ctrl[ne] = ct; e_cond[ne] = cd; e_ret[ne] = rt;
    ne++;
  endtask

  // reference model built from the requirements
  task automatic build(input logic [15:0] l, input int b, input bit ld, input bit up,
                       input bit wb, input bit us, input bit unc);
    int cnt = 0;
    bit cp, xr, fu, pt;
    int mb, off, i, j, top;
    bit pr, pcl;
    ne = 0;
    for (int k = 0; k < 16; k++) cnt += int'(l[k]);
    cp = (ld && l[b]) || cnt == 0;
    xr = us && l[15];
    fu = us && !l[15];
    pt = ld && wb && l[15];
    if (cp) push(0, 16, 0, b, 0, 0, 0, 0, 0, 0);
    mb = cp ? 16 : b;
    off = up ? 0 : cnt * 4 - 4;
    i = 0;
    while (i < 16) begin
      if (!l[i]) i++;
      else begin
        j = i + 1;
        while (j < 16 && !l[j]) j++;
        pr = ld && j < 16 && !(xr && j == 15);
        top = pr ? j : i;
        pcl = ld && top == 15 && !pt;
        push(ld ? (pr ? 2 : 1) : 3,
             (pt && i == 15) ? 17 : i,
             pr ? ((pt && j == 15) ? 17 : j) : 0,
             mb, off, !up, fu, pcl, pcl && !unc, pcl && xr);
        off = up ? off + (pr ? 8 : 4) : off - (pr ? 8 : 4);
        i = pr ? j + 1 : j;
      end
    end
    if (wb && cnt != 0) push(up ? 4 : 5, b, 0, b, cnt * 4, 0, 0, 0, 0, 0);
    if (pt) push(6, 15, 0, 17, 0, 0, 0, 1, !unc, 1);
  endtask

  task automatic run(input logic [15:0] l, input int b, input bit ld, input bit up,
                     input bit wb, input bit us, input bit unc);
    int k = 0;
    bit done = 0, stalled = 0;
    logic [41:0] held, cur;
    string t_op, t_fl, t_off;
    build(l, b, ld, up, wb, us, unc);
    @(negedge clk);
    in_list = l; in_base = 4'(b); in_load = ld; in_up = up; in_wb = wb;
    in_user = us; in_uncond = unc; in_valid = 1'b1;
    chk(in_ready === 1'b1, "R1", "in_ready idle", int'(in_ready), 1);
    @(negedge clk);
    in_valid = 1'b0;
    while (!done && k < 24) begin
      step_lfsr();
      out_ready = (lfsr[1:0] != 2'b00);
      cur = {out_opc, out_rd, out_rd2, out_base, out_off, out_dn, out_user, out_ctrl,
             out_indir, out_cond, out_ret, out_dcommit, out_last, out_valid, in_ready};
      chk(out_valid === 1'b1 && in_ready === 1'b0, "R1", "busy handshake",
          int'({out_valid, in_ready}), 2);
      if (stalled) chk(cur == held, "R1", "stall hold", int'(cur[41:10]), int'(held[41:10]));
      if (out_ready) begin
        if (k < ne) begin
          case (e_opc[k])
            0: t_op = "R4"; 2: t_op = "R5"; 4, 5: t_op = "R9"; 6: t_op = "R8"; default: t_op = "R2";
          endcase
          t_off = (e_opc[k] >= 4) ? "R9" : "R3";
          t_fl = (e_opc[k] == 6 || (ld && wb && l[15])) ? "R8" : "R7";
          chk(int'(out_opc) == e_opc[k], t_op, "opcode", int'(out_opc), e_opc[k]);
          chk(int'(out_rd) == e_rd[k] && int'(out_rd2) == e_rd2[k], t_op, "rd/rd2",
              int'({out_rd, out_rd2}), e_rd[k] * 32 + e_rd2[k]);
          chk(int'(out_base) == e_base[k], "R4", "base", int'(out_base), e_base[k]);
          chk(int'(out_off) == e_off[k] && out_dn == e_dn[k], t_off, "offset/dir",
              int'({out_off, out_dn}), e_off[k] * 2 + int'(e_dn[k]));
          chk(out_user == e_user[k], "R6", "user bank", int'(out_user), int'(e_user[k]));
          chk(out_ctrl == e_ctrl[k] && out_indir == e_ctrl[k] && out_cond == e_cond[k]
              && out_ret == e_ret[k], t_fl, "ctrl/indir/cond/ret",
              int'({out_ctrl, out_indir, out_cond, out_ret}),
              int'({e_ctrl[k], e_ctrl[k], e_cond[k], e_ret[k]}));
          chk(out_last == (k == ne - 1) && out_dcommit == (k != ne - 1), "R10", "last/dcommit",
              int'({out_last, out_dcommit}), (k == ne - 1) ? 2 : 1);
        end
        if (out_last) done = 1;
        k++;
        stalled = 0;
      end else begin
        stalled = 1;
        held = cur;
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
    chk(k == ne, "R2", "descriptor count", k, ne);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R1", "idle after last",
        int'({out_valid, in_ready}), 1);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_list = '0; in_base = '0; {in_load, in_up, in_wb, in_user, in_uncond} = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(in_ready === 1'b1 && out_valid === 1'b0, "R1", "reset state",
        int'({in_ready, out_valid}), 2);
    for (int t = 0; t < 140; t++) begin
      logic [15:0] l;
      step_lfsr();
      if (t < 16)       l = 16'(1) << t;
      else if (t == 16) l = 16'h0000;
      else if (t == 17) l = 16'hFFFF;
      else if (t == 18) l = 16'h8001;
      else if (t == 19) l = 16'h8003;
      else if (t == 20) l = 16'h8007;
      else              l = lfsr ^ 16'(t * 40503);
      for (int f = 0; f < 16; f++) begin
        run(l, (t * 7 + f) % 16, f[0], f[1], f[2], f[3], f[0] ^ t[0]);
      end
    end
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule